// File: doc/BRIEF.md
# Stack Control-Flow Bus Sequencer

This block produces the cycle-exact bus activity of the six stack-related control-flow operations of a small 8-bit processor: pushing a register, pulling a register, calling a subroutine, returning from a subroutine, returning from an interrupt, and a software break. The caller pulses a start strobe with an operation kind, the current program counter, the current stack pointer and a strict flag. The block then owns the bus for a fixed number of cycles and drives one access per cycle. It takes read data back from memory in the same cycle, and at the end it presents the new program counter and stack pointer.

The stack occupies one 256-byte page whose high address byte is a parameter (page 1 by default). All stack-pointer offsets wrap inside that page. With the strict flag set, every dummy read of the real sequence appears on the bus. With it clear, those cycles still take place, but the read strobe stays low. Write data is not carried by this block. It tells the datapath what to place on the bus through a write-select code.

Top module: `stk_seq`

## Requirements
- R1: After synchronous reset: busy_o=0, done_o=0, bus_rd_o=0, bus_wr_o=0, pc_o=0, sp_o=0.
- R2: Kind 0 (push) runs 3 cycles: read pc, dummy read pc+1, write at stack address of sp with wr_sel_o=0 (register); afterwards pc_o=pc+1 and sp_o=sp-1.
- R3: Kind 1 (pull) runs 4 cycles: read pc, dummy read pc+1, dummy read stack sp, read stack sp+1; afterwards pc_o=pc+1 and sp_o=sp+1.
- R4: Kind 2 (call) runs 6 cycles: read pc, read pc+1 (target low byte), dummy read stack sp, write stack sp with wr_sel_o=1 (PC high), write stack sp-1 with wr_sel_o=2 (PC low), read pc+2 (target high byte); pc_o becomes the target and sp_o=sp-2.
- R5: Kind 3 (return) runs 6 cycles: read pc, dummy reads pc+1 and stack sp, read stack sp+1 (low) and sp+2 (high), dummy read at the restored address; pc_o = restored+1 and sp_o=sp+2.
- R6: Kind 4 (interrupt return) runs 6 cycles: read pc, dummy reads pc+1 and stack sp, read stack sp+1 (status), sp+2 (low), sp+3 (high); pc_o = {high,low} and sp_o=sp+3.
- R7: Kind 5 (break) runs 7 cycles: read pc, dummy read pc+1, writes at stack sp, sp-1, sp-2 with wr_sel_o = 1, 2, 3 (PC high, PC low, status) in that order, then reads at BRK_VEC (low) and BRK_VEC+1 (high); pc_o = vector and sp_o=sp-3.
- R8: Every stack access uses address {STK_PAGE, (sp+offset) mod 256}, including when the offset crosses 0x00/0xFF.
- R9: At the end of every operation, sp_o equals sp plus the kind's net change, modulo 256.
- R10: With strict_i=0, dummy-read cycles keep their place in the sequence but bus_rd_o is 0 in them; all other accesses are unchanged.
- R11: A start with kind 6 or 7 is ignored: busy_o stays 0 and pc_o/sp_o are unchanged.
- R12: done_o is 1 in exactly the last cycle of a sequence, and bus_rd_o and bus_wr_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted when idle or in the last cycle) |
| kind_i | input | 3 | Operation kind 0..5 |
| strict_i | input | 1 | Show dummy reads on the bus |
| pc_i | input | 16 | Program counter at the opcode |
| sp_i | input | 8 | Stack pointer before the operation |
| rd_data_i | input | 8 | Read data for the current cycle's address |
| bus_addr_o | output | 16 | Bus address |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| wr_sel_o | output | 2 | Write data source: 0 register, 1 PC high, 2 PC low, 3 status |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last cycle of the sequence |
| pc_o | output | 16 | Program counter after the last operation |
| sp_o | output | 8 | Stack pointer after the last operation |

## Verification
The bench builds the block with its defaults: the stack in page 0x01 and the break vector at 0xFFFE. This keeps every stack address distinct from the operand and vector addresses, so a wrong address source is caught. Read data is a fixed function of the address, which makes each restored program counter a predictable value. Starting pointers of 0x00, 0x01, 0xFE and 0xFF push each offset across the page edge. The strict flag is run both ways on sequences that carry dummy reads.

// File: rtl/stk_seq_pkg.sv
// Shared types for the stack control-flow sequencer.
// Assumes 8-bit data, a 16-bit address and an 8-bit stack pointer.
package stk_seq_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int STEP_W = 3;
    localparam int KIND_W = 3;
    localparam int MAX_STEPS = 7;

    typedef enum logic [KIND_W-1:0] {
        K_PUSH = 3'd0, K_PULL = 3'd1, K_CALL = 3'd2,
        K_RET  = 3'd3, K_IRET = 3'd4, K_BRK  = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        SEL_REG = 2'd0, SEL_PCH = 2'd1, SEL_PCL = 2'd2, SEL_STAT = 2'd3
    } wsel_e;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_PC, SRC_PC1, SRC_PC2, SRC_STK, SRC_RET, SRC_VLO, SRC_VHI
    } src_e;

    // One bus access of a sequence step
    typedef struct packed {
        src_e        src;
        logic [2:0]  ofs;     // signed stack offset
        logic        rd;
        logic        wr;
        logic        dummy;
        wsel_e       sel;
        logic        cap_lo;
        logic        cap_hi;
        logic        last;
    } acc_t;

    function automatic logic kind_ok(input logic [KIND_W-1:0] k);
        return k <= 3'd5;
    endfunction

    function automatic logic [BYTE_W-1:0] sp_delta(input logic [KIND_W-1:0] k);
        case (k)
            K_PUSH:  return 8'hFF;
            K_PULL:  return 8'h01;
            K_CALL:  return 8'hFE;
            K_RET:   return 8'h02;
            K_IRET:  return 8'h03;
            default: return 8'hFD;
        endcase
    endfunction
endpackage

// File: rtl/stk_seq_ctrl.sv
// Sequence controller: accepts a start, latches the operation inputs and
// steps through the cycles until the decoder flags the last one.
// Assumes start is honoured only when idle or in the final cycle.
module stk_seq_ctrl
    import stk_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [KIND_W-1:0]    kind_i,
    input  logic                 strict_i,
    input  logic [ADDR_W-1:0]    pc_i,
    input  logic [BYTE_W-1:0]    sp_i,
    input  logic                 last_i,
    output logic                 busy_o,
    output logic [STEP_W-1:0]    step_o,
    output logic [KIND_W-1:0]    kind_o,
    output logic                 strict_o,
    output logic [ADDR_W-1:0]    pc_o,
    output logic [BYTE_W-1:0]    sp_o
);
    logic accept;

    // Start is taken when idle or on the closing cycle of a sequence
    always_comb accept = start_i && kind_ok(kind_i) && (!busy_o || last_i);

    // Latch operands and advance the step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o   <= 1'b0;
            step_o   <= '0;
            kind_o   <= '0;
            strict_o <= 1'b0;
            pc_o     <= '0;
            sp_o     <= '0;
        end else if (accept) begin
            busy_o   <= 1'b1;
            step_o   <= '0;
            kind_o   <= kind_i;
            strict_o <= strict_i;
            pc_o     <= pc_i;
            sp_o     <= sp_i;
        end else if (busy_o && last_i) begin
            busy_o <= 1'b0;
            step_o <= '0;
        end else if (busy_o) begin
            step_o <= step_o + 1'b1;
        end
    end

    a_r11_bad_kind_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !kind_ok(kind_i)) |=> !busy_o);

    a_r7_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (step_o < STEP_W'(MAX_STEPS)));
endmodule

// File: rtl/stk_seq_decode.sv
// Step decoder: maps operation kind and step index to the bus access of
// that cycle. Pure combinational; outputs all-zero when idle.
module stk_seq_decode
    import stk_seq_pkg::*;
(
    input  logic                busy_i,
    input  logic [KIND_W-1:0]   kind_i,
    input  logic [STEP_W-1:0]   step_i,
    output acc_t                acc_o
);
    function automatic acc_t rdc(input src_e s, input logic [2:0] o, input logic d,
                                 input logic cl, input logic ch, input logic l);
        acc_t a;
        a = '0;
        a.src = s; a.ofs = o; a.rd = 1'b1; a.dummy = d;
        a.cap_lo = cl; a.cap_hi = ch; a.last = l;
        return a;
    endfunction

    function automatic acc_t wrc(input logic [2:0] o, input wsel_e s, input logic l);
        acc_t a;
        a = '0;
        a.src = SRC_STK; a.ofs = o; a.wr = 1'b1; a.sel = s; a.last = l;
        return a;
    endfunction

    // Per-kind step tables
    always_comb begin
        acc_o = '0;
        if (busy_i) begin
            case (kind_i)
                K_PUSH: case (step_i)
                    3'd0: acc_o = rdc(SRC_PC,  3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
                    3'd1: acc_o = rdc(SRC_PC1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
                    default: acc_o = wrc(3'd0, SEL_REG, 1'b1);
                endcase
                K_PULL: case (step_i)
                    3'd0: acc_o = rdc(SRC_PC,  3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
                    3'd1: acc_o = rdc(SRC_PC1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
                    3'd2: acc_o = rdc(SRC_STK, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
                    default: acc_o = rdc(SRC_STK, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1);
                endcase
                K_CALL: case (step_i)
                    3'd0: acc_o = rdc(SRC_PC,  3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
                    3'd1: acc_o = rdc(SRC_PC1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
                    3'd2: acc_o = rdc(SRC_STK, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
                    3'd3: acc_o = wrc(3'd0, SEL_PCH, 1'b0);
                    3'd4: acc_o = wrc(3'b111, SEL_PCL, 1'b0);
                    default: acc_o = rdc(SRC_PC2, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
                endcase
                K_RET: case (step_i)
                    3'd0: acc_o = rdc(SRC_PC,  3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
                    3'd1: acc_o = rdc(SRC_PC1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
                    3'd2: acc_o = rdc(SRC_STK, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
                    3'd3: acc_o = rdc(SRC_STK, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
                    3'd4: acc_o = rdc(SRC_STK, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0);
                    default: acc_o = rdc(SRC_RET, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1);
                endcase
                K_IRET: case (step_i)
                    3'd0: acc_o = rdc(SRC_PC,  3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
                    3'd1: acc_o = rdc(SRC_PC1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
                    3'd2: acc_o = rdc(SRC_STK, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
                    3'd3: acc_o = rdc(SRC_STK, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
                    3'd4: acc_o = rdc(SRC_STK, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0);
                    default: acc_o = rdc(SRC_STK, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1);
                endcase
                default: case (step_i)
                    3'd0: acc_o = rdc(SRC_PC,  3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
                    3'd1: acc_o = rdc(SRC_PC1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
                    3'd2: acc_o = wrc(3'd0, SEL_PCH, 1'b0);
                    3'd3: acc_o = wrc(3'b111, SEL_PCL, 1'b0);
                    3'd4: acc_o = wrc(3'b110, SEL_STAT, 1'b0);
                    3'd5: acc_o = rdc(SRC_VLO, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
                    default: acc_o = rdc(SRC_VHI, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
                endcase
            endcase
        end
    end
endmodule

// File: rtl/stk_seq_addr.sv
// Address generator: forms the bus address from the selected source.
// Stack addresses wrap inside the stack page; pc offsets wrap at 16 bits.
module stk_seq_addr
    import stk_seq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STK_PAGE = 8'h01,
    parameter logic [ADDR_W-1:0] BRK_VEC  = 16'hFFFE
) (
    input  src_e                src_i,
    input  logic [2:0]          ofs_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [BYTE_W-1:0]   sp_i,
    input  logic [BYTE_W-1:0]   lo_i,
    input  logic [BYTE_W-1:0]   hi_i,
    output logic [ADDR_W-1:0]   addr_o
);
    logic [BYTE_W-1:0] stk_idx;

    // Sign-extended offset added modulo 256
    always_comb stk_idx = sp_i + {{(BYTE_W-3){ofs_i[2]}}, ofs_i};

    // Address source multiplexer
    always_comb begin
        case (src_i)
            SRC_PC:  addr_o = pc_i;
            SRC_PC1: addr_o = pc_i + ADDR_W'(1);
            SRC_PC2: addr_o = pc_i + ADDR_W'(2);
            SRC_STK: addr_o = {STK_PAGE, stk_idx};
            SRC_RET: addr_o = {hi_i, lo_i};
            SRC_VLO: addr_o = BRK_VEC;
            SRC_VHI: addr_o = BRK_VEC + ADDR_W'(1);
            default: addr_o = '0;
        endcase
    end
endmodule

// File: rtl/stk_seq_result.sv
// Result unit: captures the low and high address bytes read during a
// sequence and, in its last cycle, registers the new pc and sp.
// Assumes rd_data_i is valid in the cycle of the read.
module stk_seq_result
    import stk_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                busy_i,
    input  logic                done_i,
    input  logic                cap_lo_i,
    input  logic                cap_hi_i,
    input  logic [KIND_W-1:0]   kind_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [BYTE_W-1:0]   sp_i,
    input  logic [BYTE_W-1:0]   rd_data_i,
    output logic [BYTE_W-1:0]   lo_o,
    output logic [BYTE_W-1:0]   hi_o,
    output logic [ADDR_W-1:0]   pc_o,
    output logic [BYTE_W-1:0]   sp_o
);
    logic [BYTE_W-1:0] hi_now;
    logic [ADDR_W-1:0] pc_next;

    // Final pc: high byte may arrive in the closing cycle itself
    always_comb begin
        hi_now = cap_hi_i ? rd_data_i : hi_o;
        case (kind_i)
            K_PUSH, K_PULL: pc_next = pc_i + ADDR_W'(1);
            K_RET:          pc_next = {hi_now, lo_o} + ADDR_W'(1);
            default:        pc_next = {hi_now, lo_o};
        endcase
    end

    // Byte capture and end-of-sequence update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o <= '0;
            hi_o <= '0;
            pc_o <= '0;
            sp_o <= '0;
        end else begin
            if (busy_i && cap_lo_i) lo_o <= rd_data_i;
            if (busy_i && cap_hi_i) hi_o <= rd_data_i;
            if (done_i) begin
                pc_o <= pc_next;
                sp_o <= sp_i + sp_delta(kind_i);
            end
        end
    end

    a_r9_sp_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(sp_o));
endmodule

// File: rtl/stk_seq.sv
// Stack control-flow bus sequencer top. Drives one bus access per cycle
// for push, pull, call, return, interrupt return and break, hiding the
// dummy reads when strict mode is off. Assumes a single-cycle memory.
module stk_seq
    import stk_seq_pkg::*;
#(
    parameter logic [7:0]  STK_PAGE = 8'h01,
    parameter logic [15:0] BRK_VEC  = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [2:0]  kind_i,
    input  logic        strict_i,
    input  logic [15:0] pc_i,
    input  logic [7:0]  sp_i,
    input  logic [7:0]  rd_data_i,
    output logic [15:0] bus_addr_o,
    output logic        bus_rd_o,
    output logic        bus_wr_o,
    output logic [1:0]  wr_sel_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] pc_o,
    output logic [7:0]  sp_o
);
    logic [STEP_W-1:0] step;
    logic [KIND_W-1:0] kind_q;
    logic              strict_q;
    logic [ADDR_W-1:0] pc_q;
    logic [BYTE_W-1:0] sp_q;
    logic [BYTE_W-1:0] lo_q, hi_q;
    acc_t              acc;

    stk_seq_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .strict_i(strict_i), .pc_i(pc_i), .sp_i(sp_i), .last_i(acc.last),
        .busy_o(busy_o), .step_o(step), .kind_o(kind_q), .strict_o(strict_q),
        .pc_o(pc_q), .sp_o(sp_q)
    );

    stk_seq_decode i_dec (
        .busy_i(busy_o), .kind_i(kind_q), .step_i(step), .acc_o(acc)
    );

    stk_seq_addr #(.STK_PAGE(STK_PAGE), .BRK_VEC(BRK_VEC)) i_addr (
        .src_i(acc.src), .ofs_i(acc.ofs), .pc_i(pc_q), .sp_i(sp_q),
        .lo_i(lo_q), .hi_i(hi_q), .addr_o(bus_addr_o)
    );

    stk_seq_result i_res (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_o), .done_i(done_o),
        .cap_lo_i(acc.cap_lo), .cap_hi_i(acc.cap_hi), .kind_i(kind_q),
        .pc_i(pc_q), .sp_i(sp_q), .rd_data_i(rd_data_i),
        .lo_o(lo_q), .hi_o(hi_q), .pc_o(pc_o), .sp_o(sp_o)
    );

    // Bus strobes; dummy reads are masked unless strict
    always_comb begin
        done_o   = busy_o && acc.last;
        bus_rd_o = busy_o && acc.rd && !(acc.dummy && !strict_q);
        bus_wr_o = busy_o && acc.wr;
        wr_sel_o = acc.wr ? acc.sel : SEL_REG;
    end

    a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_o && bus_wr_o));

    a_r12_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !busy_o);

    a_r8_writes_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_o |-> (bus_addr_o[15:8] == STK_PAGE));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!bus_rd_o && !bus_wr_o && !done_o));
endmodule

// File: tb/test_stk_seq.sv
`timescale 1ns/1ps
module test_stk_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  kind = '0;
    logic        strict = 1'b1;
    logic [15:0] pc = '0;
    logic [7:0]  sp = '0;
    logic [7:0]  rd_data;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr, busy, done;
    logic [1:0]  wr_sel;
    logic [15:0] pc_out;
    logic [7:0]  sp_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    // Memory model: data is a fixed function of the address
    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    function automatic logic [15:0] stk(input logic [7:0] x);
        return {8'h01, x};
    endfunction

    assign rd_data = mem_f(bus_addr);

    stk_seq i_stk_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind),
        .strict_i(strict), .pc_i(pc), .sp_i(sp), .rd_data_i(rd_data),
        .bus_addr_o(bus_addr), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr),
        .wr_sel_o(wr_sel), .busy_o(busy), .done_o(done),
        .pc_o(pc_out), .sp_o(sp_out)
    );

    logic [15:0] ea [8];
    logic        er [8];
    logic        ew [8];
    logic [1:0]  es [8];
    int          n;
    bit          cur_strict;

    task automatic add(input logic [15:0] a, input logic r, input logic w,
                       input logic [1:0] s, input logic dummy);
        ea[n] = a;
        er[n] = r && !(dummy && !cur_strict);
        ew[n] = w;
        es[n] = s;
        n++;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !bus_rd && !bus_wr, "R1", "idle strobes",
              {busy, done, bus_rd, bus_wr}, 0);
        check(pc_out == 16'h0 && sp_out == 8'h0, "R1", "pc/sp",
              {pc_out, sp_out}, 0);
    endtask

    // Run one operation and compare every bus cycle and the result
    task automatic run_seq(input logic [2:0] k, input logic [15:0] p,
                           input logic [7:0] s, input bit st, input string tag);
        logic [15:0] epc, ret;
        logic [7:0]  esp;
        n = 0;
        cur_strict = st;
        case (k)
            3'd0: begin
                add(p, 1, 0, 0, 0); add(p + 16'd1, 1, 0, 0, 1);
                add(stk(s), 0, 1, 2'd0, 0);
                epc = p + 16'd1; esp = s - 8'd1;
            end
            3'd1: begin
                add(p, 1, 0, 0, 0); add(p + 16'd1, 1, 0, 0, 1);
                add(stk(s), 1, 0, 0, 1); add(stk(s + 8'd1), 1, 0, 0, 0);
                epc = p + 16'd1; esp = s + 8'd1;
            end
            3'd2: begin
                add(p, 1, 0, 0, 0); add(p + 16'd1, 1, 0, 0, 0);
                add(stk(s), 1, 0, 0, 1); add(stk(s), 0, 1, 2'd1, 0);
                add(stk(s - 8'd1), 0, 1, 2'd2, 0); add(p + 16'd2, 1, 0, 0, 0);
                epc = {mem_f(p + 16'd2), mem_f(p + 16'd1)}; esp = s - 8'd2;
            end
            3'd3: begin
                ret = {mem_f(stk(s + 8'd2)), mem_f(stk(s + 8'd1))};
                add(p, 1, 0, 0, 0); add(p + 16'd1, 1, 0, 0, 1);
                add(stk(s), 1, 0, 0, 1); add(stk(s + 8'd1), 1, 0, 0, 0);
                add(stk(s + 8'd2), 1, 0, 0, 0); add(ret, 1, 0, 0, 1);
                epc = ret + 16'd1; esp = s + 8'd2;
            end
            3'd4: begin
                add(p, 1, 0, 0, 0); add(p + 16'd1, 1, 0, 0, 1);
                add(stk(s), 1, 0, 0, 1); add(stk(s + 8'd1), 1, 0, 0, 0);
                add(stk(s + 8'd2), 1, 0, 0, 0); add(stk(s + 8'd3), 1, 0, 0, 0);
                epc = {mem_f(stk(s + 8'd3)), mem_f(stk(s + 8'd2))}; esp = s + 8'd3;
            end
            default: begin
                add(p, 1, 0, 0, 0); add(p + 16'd1, 1, 0, 0, 1);
                add(stk(s), 0, 1, 2'd1, 0); add(stk(s - 8'd1), 0, 1, 2'd2, 0);
                add(stk(s - 8'd2), 0, 1, 2'd3, 0);
                add(16'hFFFE, 1, 0, 0, 0); add(16'hFFFF, 1, 0, 0, 0);
                epc = {mem_f(16'hFFFF), mem_f(16'hFFFE)}; esp = s - 8'd3;
            end
        endcase
        @(negedge clk);
        kind = k; pc = p; sp = s; strict = st; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            check((bus_rd == er[i]) && (bus_wr == ew[i]) &&
                  (done == (i == n - 1)) &&
                  ((!er[i] && !ew[i]) || bus_addr == ea[i]) &&
                  (!ew[i] || wr_sel == es[i]),
                  tag, $sformatf("cycle %0d addr/rd/wr/sel/done", i),
                  {bus_addr, 7'd0, bus_rd, bus_wr, wr_sel, done},
                  {ea[i], 7'd0, er[i], ew[i], es[i], 1'(i == n - 1)});
            // R12: read and write never together
            check(!(bus_rd && bus_wr), "R12", "rd/wr exclusive",
                  {bus_rd, bus_wr}, 0);
            @(negedge clk);
        end
        check(!busy && pc_out == epc, tag, "final pc", {busy, pc_out}, {1'b0, epc});
        check(sp_out == esp, "R9", "final sp", sp_out, esp);
    endtask

    task automatic bad_kinds();
        logic [15:0] old_pc;
        logic [7:0]  old_sp;
        old_pc = pc_out;
        old_sp = sp_out;
        for (int k = 6; k < 8; k++) begin
            @(negedge clk);
            kind = 3'(k); pc = 16'h5555; sp = 8'h44; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(!busy && !bus_rd && !bus_wr, "R11", "busy after bad kind",
                  {busy, bus_rd, bus_wr}, 0);
            @(negedge clk);
            check(pc_out == old_pc && sp_out == old_sp, "R11", "pc/sp unchanged",
                  {pc_out, sp_out}, {old_pc, old_sp});
        end
    endtask

    initial begin
        do_reset();
        run_seq(3'd0, 16'h1234, 8'hFD, 1'b1, "R2");
        run_seq(3'd1, 16'h2000, 8'h80, 1'b1, "R3");
        run_seq(3'd2, 16'h40FE, 8'hF0, 1'b1, "R4");
        run_seq(3'd3, 16'h3456, 8'h10, 1'b1, "R5");
        run_seq(3'd4, 16'h6789, 8'h20, 1'b1, "R6");
        run_seq(3'd5, 16'h0ABC, 8'hC0, 1'b1, "R7");
        // R8: stack offsets crossing the page edge
        run_seq(3'd1, 16'h2100, 8'hFF, 1'b1, "R8");
        run_seq(3'd2, 16'h4000, 8'h00, 1'b1, "R8");
        run_seq(3'd3, 16'h3000, 8'hFE, 1'b1, "R8");
        run_seq(3'd4, 16'h7000, 8'hFE, 1'b1, "R8");
        run_seq(3'd5, 16'h0800, 8'h01, 1'b1, "R8");
        run_seq(3'd0, 16'hFFFF, 8'h00, 1'b1, "R8");
        // R10: dummy reads hidden when not strict
        run_seq(3'd1, 16'h2222, 8'h33, 1'b0, "R10");
        run_seq(3'd3, 16'h3333, 8'h44, 1'b0, "R10");
        run_seq(3'd5, 16'h4444, 8'h55, 1'b0, "R10");
        bad_kinds();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule